// File: doc/BRIEF.md
# Display Controller Host Register Port

This block is the register file a display controller exposes to its host processor over a 16-bit parallel bus. A data/command select line sets the meaning of each bus cycle. A command cycle, with select low, loads an 8-bit register index. Data cycles, with select high, write or read the register at that index. The index then moves on by itself, so the host can stream through neighbouring registers without issuing a new command for each one.

Two indirect tables hang off the map: a 32-entry filter coefficient table and a 256-entry gamma table. Each table has its own sub-index register and its own data port. The sub-index advances on every data access. The main index stays parked on a table's data port, so a whole table can be written as one burst of data cycles. The register file also holds:
- an interrupt status byte that events set and host writes clear by AND,
- four 10-bit window coordinates, each split into a low byte and a high byte,
- a group of masked plain storage registers that configure logic outside this block.

Top module: `disp_regport`

## Requirements
- R1: A write with `sel` low loads `wdata[7:0]` into the register index, and nothing else changes.
- R2: A write with `sel` high updates the register at the current index. The index then advances by 2, modulo 256. At the streaming ports 0x90 (pixel data), 0x5A (filter coefficient data) and 0xB8 (gamma data) the index does not move.
- R3: While `rd_en` is high and `wr_en` is low, `rdata[7:0]` shows the register at the current index and `rdata[15:8]` is 0. The index advances by 1 after the read only if `sel` is high. Reads with `sel` low have no side effect anywhere. `wr_en` takes priority over `rd_en`.
- R4: Writing 0x58 sets the filter sub-index to `wdata[4:0]`, and reading 0x58 returns the sub-index, which is 6 bits wide. A data-cycle write to 0x5A stores into the entry at the sub-index, and a data-cycle read of 0x5A returns that entry; either one then increments the sub-index. Once the sub-index reaches 32, accesses to 0x5A store nothing, reads return 0, and the sub-index stays at 32.
- R5: 0xB6 holds the 8-bit gamma sub-index. A data-cycle read or write of 0xB8 accesses the table entry at the sub-index and then increments the sub-index modulo 256.
- R6: Each 10-bit window coordinate has a low register holding bits 7:0 and a high register whose bits 1:0 hold bits 9:8. The four coordinates are x start (0x6C/0x6E), y start (0x70/0x72), x end (0x74/0x76) and y end (0x78/0x7A). A write to one half keeps the other half. The high register reads back bits 9:8 in bits 1:0.
- R7: At 0xF6, a data write ANDs `wdata[7:0]` into the interrupt status. In the same cycle, after the AND, `evt_set` is ORed in.
- R8: Register 0x00 always reads 0xA5 and register 0x02 always reads 0x83, and writes to either are ignored. Register 0xE8 always reads with bit 5 set.
- R9: Each masked register stores the written byte ANDed with its mask. Register, mask and reset value: 0x0C, 0x77, 0x32 (clock synthesiser mode); 0x0E, 0xFF, 0x00; 0x28, 0xFF, 0x74; 0x2C, 0xFF, 0x03; 0x32, 0xFF, 0x02; 0x3C, 0x82, 0x80; 0x60, 0xB0, 0x00; 0x62, 0x30, 0x30; 0x68, 0xB7, 0x00 (display mode); 0x6A, 0xFB, 0x00 (effects); 0xE6, 0x83, 0x02 (power save); 0xE8, 0x1B, 0x00.
- R10: Any index not named in R4 to R9 reads 0 and ignores writes. This includes the pixel data port 0x90.
- R11: A synchronous active-high `rst` returns every register to its reset value. The index, both sub-indices, the interrupt status, the window coordinates and every table entry reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe for this cycle |
| rd_en | input | 1 | Host read strobe for this cycle |
| sel | input | 1 | High: data cycle, low: command cycle |
| wdata | input | 16 | Host write value |
| evt_set | input | 8 | Interrupt event bits to set in the status byte |
| rdata | output | 16 | Read value for the current index |

## Verification
Streams of data writes across the index space separate the step of 2 from the hold on the streaming ports and from the wrap at 0xFF. Read bursts with `sel` high and with `sel` low, issued at the same table port, show whether the table sub-index moves only on data cycles. The filter table is driven past entry 31 so the end guard can be seen at the ports, and the gamma table is driven across entry 255 so its wrap can be seen. Writes to only one half of a window coordinate show whether the other half is kept. An event arriving in the same cycle as a clearing write shows the order in which the interrupt status combines the two.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int BYTE_W = 8;
    localparam int NPLAIN = 12;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t IDX_REV      = 8'h00;
    localparam byte_t IDX_CFG      = 8'h02;
    localparam byte_t IDX_COEF_IX  = 8'h58;
    localparam byte_t IDX_COEF_DAT = 8'h5A;
    localparam byte_t IDX_WIN_BASE = 8'h6C;
    localparam byte_t IDX_PIXEL    = 8'h90;
    localparam byte_t IDX_GAM_IX   = 8'hB6;
    localparam byte_t IDX_GAM_DAT  = 8'hB8;
    localparam byte_t IDX_NDSTAT   = 8'hE8;
    localparam byte_t IDX_IRQ      = 8'hF6;

    localparam byte_t REV_VALUE    = 8'hA5;
    localparam byte_t CFG_VALUE    = 8'h83;
    localparam byte_t NDSTAT_FORCE = 8'h20;

    // masked storage registers: index, write mask, reset value
    localparam byte_t PLAIN_ADDR [NPLAIN] = '{
        8'h0C, 8'h0E, 8'h28, 8'h2C, 8'h32, 8'h3C,
        8'h60, 8'h62, 8'h68, 8'h6A, 8'hE6, 8'hE8};
    localparam byte_t PLAIN_MASK [NPLAIN] = '{
        8'h77, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h82,
        8'hB0, 8'h30, 8'hB7, 8'hFB, 8'h83, 8'h1B};
    localparam byte_t PLAIN_RST  [NPLAIN] = '{
        8'h32, 8'h00, 8'h74, 8'h03, 8'h02, 8'h80,
        8'h00, 8'h30, 8'h00, 8'h00, 8'h02, 8'h00};

    typedef struct packed {
        byte_t idx;
        byte_t irq;
    } host_st_t;

    function automatic logic is_stream_port(input byte_t ix);
        return (ix == IDX_PIXEL) || (ix == IDX_COEF_DAT) || (ix == IDX_GAM_DAT);
    endfunction

endpackage

// File: rtl/dpr_plain_bank.sv
module dpr_plain_bank
    import dpr_pkg::*;
#(
    parameter int NREG = NPLAIN
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_stb,
    input  byte_t idx,
    input  byte_t wbyte,
    output logic  hit,
    output byte_t rbyte
);

    typedef struct packed {
        logic [NREG-1:0][BYTE_W-1:0] val;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        hit   = 1'b0;
        rbyte = '0;
        for (int i = 0; i < NREG; i++) begin
            if (idx == PLAIN_ADDR[i]) begin
                hit   = 1'b1;
                rbyte = st_q.val[i];
                if (wr_stb) begin
                    st_d.val[i] = wbyte & PLAIN_MASK[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                st_q.val[i] <= PLAIN_RST[i];
            end
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dpr_win_bank.sv
module dpr_win_bank
    import dpr_pkg::*;
#(
    parameter int    NCOORD = 4,
    parameter int    CW     = 10,
    parameter byte_t BASE   = IDX_WIN_BASE
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_stb,
    input  byte_t idx,
    input  byte_t wbyte,
    output logic  hit,
    output byte_t rbyte
);

    localparam int HI_W = CW - BYTE_W;

    typedef struct packed {
        logic [NCOORD-1:0][CW-1:0] c;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        hit   = 1'b0;
        rbyte = '0;
        for (int k = 0; k < NCOORD; k++) begin
            if (idx == byte_t'(BASE + byte_t'(4 * k))) begin
                hit   = 1'b1;
                rbyte = st_q.c[k][BYTE_W-1:0];
                if (wr_stb) begin
                    st_d.c[k][BYTE_W-1:0] = wbyte;
                end
            end
            if (idx == byte_t'(BASE + byte_t'(4 * k + 2))) begin
                hit   = 1'b1;
                rbyte = byte_t'(st_q.c[k][CW-1:BYTE_W]);
                if (wr_stb) begin
                    st_d.c[k][CW-1:BYTE_W] = wbyte[HI_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dpr_coef_tbl.sv
module dpr_coef_tbl
    import dpr_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int IW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ix_wr,
    input  logic          dat_wr,
    input  logic          dat_rd,
    input  byte_t         wbyte,
    output logic [IW-1:0] ix_out,
    output byte_t         dat_out
);

    localparam logic [IW-1:0] LIMIT = IW'(DEPTH);

    typedef struct packed {
        logic [IW-1:0]                ix;
        logic [DEPTH-1:0][BYTE_W-1:0] ent;
    } coef_st_t;

    coef_st_t st_d, st_q;
    logic     in_range;

    always_comb begin
        st_d     = st_q;
        in_range = (st_q.ix < LIMIT);
        ix_out   = st_q.ix;
        dat_out  = in_range ? st_q.ent[st_q.ix[IW-2:0]] : '0;
        if (ix_wr) begin
            st_d.ix = {1'b0, wbyte[IW-2:0]};
        end else if (in_range && (dat_wr || dat_rd)) begin
            if (dat_wr) begin
                st_d.ent[st_q.ix[IW-2:0]] = wbyte;
            end
            st_d.ix = st_q.ix + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dpr_gamma_tbl.sv
module dpr_gamma_tbl
    import dpr_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ix_wr,
    input  logic  dat_wr,
    input  logic  dat_rd,
    input  byte_t wbyte,
    output byte_t ix_out,
    output byte_t dat_out
);

    typedef struct packed {
        logic [IW-1:0]                ix;
        logic [DEPTH-1:0][BYTE_W-1:0] ent;
    } gam_st_t;

    gam_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        ix_out  = byte_t'(st_q.ix);
        dat_out = st_q.ent[st_q.ix];
        if (ix_wr) begin
            st_d.ix = wbyte[IW-1:0];
        end else if (dat_wr || dat_rd) begin
            if (dat_wr) begin
                st_d.ent[st_q.ix] = wbyte;
            end
            st_d.ix = st_q.ix + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/disp_regport.sv
module disp_regport
    import dpr_pkg::*;
#(
    parameter int HOST_W      = 16,
    parameter int COEF_DEPTH  = 32,
    parameter int GAMMA_DEPTH = 256,
    parameter int WIN_COORDS  = 4,
    parameter int WIN_W       = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              sel,
    input  logic [HOST_W-1:0] wdata,
    input  logic [7:0]        evt_set,
    output logic [HOST_W-1:0] rdata
);

    localparam int CIW = $clog2(COEF_DEPTH) + 1;

    host_st_t st_d, st_q;

    logic     wr_cmd, wr_dat, rd_dat;
    byte_t    wbyte, rbyte;
    logic     plain_hit, win_hit;
    byte_t    plain_rd, win_rd, gam_ix, gam_rd, coef_rd;
    logic [CIW-1:0] coef_ix;
    byte_t    idx_q;

    assign idx_q  = st_q.idx;
    assign wbyte  = wdata[BYTE_W-1:0];
    assign wr_cmd = wr_en && !sel;
    assign wr_dat = wr_en && sel;
    assign rd_dat = rd_en && !wr_en && sel;

    dpr_plain_bank #(.NREG(NPLAIN)) u_plain (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_dat),
        .idx    (st_q.idx),
        .wbyte  (wbyte),
        .hit    (plain_hit),
        .rbyte  (plain_rd)
    );

    dpr_win_bank #(.NCOORD(WIN_COORDS), .CW(WIN_W), .BASE(IDX_WIN_BASE)) u_win (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_dat),
        .idx    (st_q.idx),
        .wbyte  (wbyte),
        .hit    (win_hit),
        .rbyte  (win_rd)
    );

    dpr_coef_tbl #(.DEPTH(COEF_DEPTH), .IW(CIW)) u_coef (
        .clk     (clk),
        .rst     (rst),
        .ix_wr   (wr_dat && (st_q.idx == IDX_COEF_IX)),
        .dat_wr  (wr_dat && (st_q.idx == IDX_COEF_DAT)),
        .dat_rd  (rd_dat && (st_q.idx == IDX_COEF_DAT)),
        .wbyte   (wbyte),
        .ix_out  (coef_ix),
        .dat_out (coef_rd)
    );

    dpr_gamma_tbl #(.DEPTH(GAMMA_DEPTH)) u_gam (
        .clk     (clk),
        .rst     (rst),
        .ix_wr   (wr_dat && (st_q.idx == IDX_GAM_IX)),
        .dat_wr  (wr_dat && (st_q.idx == IDX_GAM_DAT)),
        .dat_rd  (rd_dat && (st_q.idx == IDX_GAM_DAT)),
        .wbyte   (wbyte),
        .ix_out  (gam_ix),
        .dat_out (gam_rd)
    );

    always_comb begin
        st_d = st_q;
        if (wr_cmd) begin
            st_d.idx = wbyte;
        end else if (wr_dat) begin
            if (!is_stream_port(st_q.idx)) begin
                st_d.idx = st_q.idx + 8'd2;
            end
        end else if (rd_dat) begin
            st_d.idx = st_q.idx + 8'd1;
        end
        if (wr_dat && (st_q.idx == IDX_IRQ)) begin
            st_d.irq = st_q.irq & wbyte;
        end
        st_d.irq = st_d.irq | evt_set;
    end

    always_comb begin
        unique case (st_q.idx)
            IDX_REV:      rbyte = REV_VALUE;
            IDX_CFG:      rbyte = CFG_VALUE;
            IDX_COEF_IX:  rbyte = byte_t'(coef_ix);
            IDX_COEF_DAT: rbyte = coef_rd;
            IDX_GAM_IX:   rbyte = gam_ix;
            IDX_GAM_DAT:  rbyte = gam_rd;
            IDX_IRQ:      rbyte = st_q.irq;
            IDX_NDSTAT:   rbyte = plain_rd | NDSTAT_FORCE;
            default: begin
                if (plain_hit) begin
                    rbyte = plain_rd;
                end else if (win_hit) begin
                    rbyte = win_rd;
                end else begin
                    rbyte = '0;
                end
            end
        endcase
        rdata = {{(HOST_W-BYTE_W){1'b0}}, rbyte};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dpr_chk.sv
module dpr_chk
    import dpr_pkg::*;
#(
    parameter int HOST_W = 16,
    parameter int CIW    = 6,
    parameter int CLIM   = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic              sel,
    input logic [HOST_W-1:0] wdata,
    input logic [7:0]        evt_set,
    input logic [HOST_W-1:0] rdata,
    input logic [7:0]        idx,
    input logic [7:0]        irq,
    input logic [CIW-1:0]    cix
);

    assert_cmd_load_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sel) |=> (idx == $past(wdata[7:0])));

    assert_step_two_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel && !is_stream_port(idx)) |=> (idx == 8'($past(idx) + 8'd2)));

    assert_stream_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel && is_stream_port(idx)) |=> $stable(idx));

    assert_read_step_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && sel) |=> (idx == 8'($past(idx) + 8'd1)));

    assert_read_still_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && !sel) |=> $stable(idx));

    assert_coef_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cix <= CIW'(CLIM));

    assert_coef_guard_R4: assert property (@(posedge clk) disable iff (rst)
        ((idx == IDX_COEF_DAT) && (cix == CIW'(CLIM))) |-> (rdata == '0));

    assert_irq_noset_R7: assert property (@(posedge clk) disable iff (rst)
        (evt_set == 8'h00) |=> ((irq & ~$past(irq)) == 8'h00));

    assert_revision_R8: assert property (@(posedge clk) disable iff (rst)
        (idx == IDX_REV) |-> (rdata == HOST_W'(REV_VALUE)));

endmodule

bind disp_regport dpr_chk #(.HOST_W(HOST_W), .CIW(CIW), .CLIM(COEF_DEPTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .sel     (sel),
    .wdata   (wdata),
    .evt_set (evt_set),
    .rdata   (rdata),
    .idx     (idx_q),
    .irq     (st_q.irq),
    .cix     (coef_ix)
);

// File: tb/sim_disp_regport.sv
module sim_disp_regport;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        sel = 1'b0;
    logic [15:0] wdata = '0;
    logic [7:0]  evt_set = '0;
    logic [15:0] rdata;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    disp_regport u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .sel     (sel),
        .wdata   (wdata),
        .evt_set (evt_set),
        .rdata   (rdata)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic s, input logic [15:0] v);
        @(negedge clk);
        sel = s; wdata = v; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] a);
        bus_wr(1'b0, {8'h00, a});
    endtask

    task automatic dat(input logic [7:0] v);
        bus_wr(1'b1, {8'h00, v});
    endtask

    task automatic rd(input logic s, output logic [15:0] v);
        @(negedge clk);
        sel = s; rd_en = 1'b1;
        #5 v = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input logic s, input string req, input logic [15:0] exp);
        logic [15:0] v;
        rd(s, v);
        check(req, v, exp);
    endtask

    task automatic t_reset_state();
        cmd(8'h00);
        rd_chk(1'b1, "R8 revision", 16'h00A5);
        rd_chk(1'b1, "R10 unknown 0x01", 16'h0000);
        rd_chk(1'b1, "R8 config readback", 16'h0083);
        cmd(8'h0C); rd_chk(1'b0, "R11 reset synth mode", 16'h0032);
        cmd(8'hE6); rd_chk(1'b0, "R11 reset power save", 16'h0002);
        cmd(8'h62); rd_chk(1'b0, "R11 reset xlate1", 16'h0030);
        cmd(8'hE8); rd_chk(1'b0, "R8 nd status bit5", 16'h0020);
        cmd(8'hF6); rd_chk(1'b0, "R11 reset irq", 16'h0000);
    endtask

    task automatic t_autoinc();
        cmd(8'h0C);
        dat(8'hFF);
        dat(8'hAB);
        cmd(8'h0C);
        rd_chk(1'b0, "R3 read sel low", 16'h0077);
        rd_chk(1'b0, "R3 no step sel low", 16'h0077);
        rd_chk(1'b1, "R2 step2 first write", 16'h0077);
        rd_chk(1'b1, "R10 unknown 0x0D", 16'h0000);
        rd_chk(1'b1, "R2 step2 second write", 16'h00AB);
    endtask

    task automatic t_masks();
        cmd(8'h68); dat(8'hFF); dat(8'hFF);
        cmd(8'hE6); dat(8'hFF); dat(8'hFF);
        cmd(8'h3C); dat(8'hFF);
        cmd(8'h68); rd_chk(1'b0, "R9 display mode mask", 16'h00B7);
        cmd(8'h6A); rd_chk(1'b0, "R9 effects mask", 16'h00FB);
        cmd(8'hE6); rd_chk(1'b0, "R9 power mask", 16'h0083);
        cmd(8'hE8); rd_chk(1'b0, "R8 R9 nd status", 16'h003B);
        cmd(8'h3C); rd_chk(1'b0, "R9 clock polarity mask", 16'h0082);
    endtask

    task automatic t_wrap_and_ignore();
        cmd(8'hFE); dat(8'h55);
        rd_chk(1'b0, "R2 index wrap to 0", 16'h00A5);
        cmd(8'h00); dat(8'h12);
        cmd(8'h00); rd_chk(1'b0, "R8 revision ignores write", 16'h00A5);
        cmd(8'h04); dat(8'hFF);
        cmd(8'h04); rd_chk(1'b0, "R10 unknown ignores write", 16'h0000);
        cmd(8'h90); dat(8'h01); dat(8'h02);
        rd_chk(1'b0, "R10 pixel port reads 0", 16'h0000);
    endtask

    task automatic t_coef();
        cmd(8'h58); dat(8'h3E);
        dat(8'h11); dat(8'h22); dat(8'h33);
        cmd(8'h58); rd_chk(1'b0, "R4 index parks at 32", 16'h0020);
        cmd(8'h58); dat(8'h1E);
        rd_chk(1'b1, "R4 entry 30", 16'h0011);
        cmd(8'h5A);
        rd_chk(1'b0, "R4 entry 31 sel low", 16'h0022);
        rd_chk(1'b0, "R4 no sub step sel low", 16'h0022);
        rd_chk(1'b1, "R4 entry 31", 16'h0022);
        cmd(8'h5A); rd_chk(1'b0, "R4 guard reads 0", 16'h0000);
        cmd(8'h58); dat(8'h00); dat(8'hA1); dat(8'hB2);
        cmd(8'h58); dat(8'h00);
        rd_chk(1'b1, "R4 entry 0", 16'h00A1);
        cmd(8'h5A); rd_chk(1'b1, "R4 entry 1", 16'h00B2);
    endtask

    task automatic t_gamma();
        cmd(8'hB6); dat(8'hFE);
        dat(8'h10); dat(8'h20); dat(8'h30);
        cmd(8'hB6); rd_chk(1'b0, "R5 sub index wrapped", 16'h0001);
        cmd(8'hB6); dat(8'hFE);
        cmd(8'hB8); rd_chk(1'b1, "R5 entry 254", 16'h0010);
        cmd(8'hB8); rd_chk(1'b1, "R5 entry 255", 16'h0020);
        cmd(8'hB8); rd_chk(1'b1, "R5 entry 0 after wrap", 16'h0030);
    endtask

    task automatic t_window();
        cmd(8'h6C); dat(8'h5A); dat(8'hFF);
        cmd(8'h6C);
        rd_chk(1'b1, "R6 x start low", 16'h005A);
        rd_chk(1'b1, "R10 unknown 0x6D", 16'h0000);
        rd_chk(1'b1, "R6 x start high", 16'h0003);
        cmd(8'h6C); dat(8'h12);
        cmd(8'h6E); rd_chk(1'b0, "R6 high kept", 16'h0003);
        cmd(8'h6E); dat(8'h01);
        cmd(8'h6C); rd_chk(1'b0, "R6 low kept", 16'h0012);
        cmd(8'h78); dat(8'h34); dat(8'h02);
        cmd(8'h78); rd_chk(1'b0, "R6 y end low", 16'h0034);
        cmd(8'h7A); rd_chk(1'b0, "R6 y end high", 16'h0002);
    endtask

    task automatic t_irq();
        @(negedge clk); evt_set = 8'hF0;
        @(posedge clk); #1; evt_set = 8'h00;
        cmd(8'hF6); rd_chk(1'b0, "R7 events set", 16'h00F0);
        dat(8'h3F);
        cmd(8'hF6); rd_chk(1'b0, "R7 write ANDs", 16'h0030);
        @(negedge clk);
        sel = 1'b1; wdata = 16'h0000; wr_en = 1'b1; evt_set = 8'h01;
        @(posedge clk); #1;
        wr_en = 1'b0; evt_set = 8'h00;
        cmd(8'hF6); rd_chk(1'b0, "R7 event after clear", 16'h0001);
    endtask

    task automatic t_mid_reset();
        cmd(8'h0C); dat(8'h11);
        cmd(8'h78); dat(8'h99);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        rd_chk(1'b0, "R11 index reset", 16'h00A5);
        cmd(8'h0C); rd_chk(1'b0, "R11 synth mode reset", 16'h0032);
        cmd(8'h78); rd_chk(1'b0, "R11 window reset", 16'h0000);
        cmd(8'h5A); rd_chk(1'b0, "R11 coef entry reset", 16'h0000);
        cmd(8'hB8); rd_chk(1'b0, "R11 gamma entry reset", 16'h0000);
        cmd(8'hF6); rd_chk(1'b0, "R11 irq reset", 16'h0000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset_state();
        t_autoinc();
        t_masks();
        t_wrap_and_ignore();
        t_coef();
        t_gamma();
        t_window();
        t_irq();
        t_mid_reset();
        finish_run();
    end

endmodule